// File: doc/BRIEF.md
# Character Style Parameter Register

This block holds the three settings that shape how text characters are stroked: a two-bit size code, a rotation select and a writing-speed select. A controller writes them through a 16-bit data word and a set strobe. The word carries two active-low change-enable bits, one for each group of fields. The size and rotation fields form one group and the speed field forms the other. A single write can therefore update the shape group, the speed group, both groups, or neither.

A separate read strobe places the stored settings back on the output word. The two change-enable positions always read as 1 and every unlisted bit reads as 0. The block also turns the size code into a stroke-clock divide ratio, and it presents rotation and slow-speed flags for the stroke timing and axis-swap logic downstream. The settings stay in place until the next qualified write.

Top module: `charStyleReg`

## Requirements
- R1: On a clock edge with `setStrobe` high and `busIn[3]` low, the size code loads from `busIn[1:0]` and the orientation bit loads from `busIn[2]`. Both are visible on the outputs after that edge.
- R2: On a clock edge with `setStrobe` high and `busIn[10]` low, the speed bit loads from `busIn[9]`.
- R3: A set strobe with `busIn[3]` high leaves the size code and rotation unchanged, whatever the speed group does.
- R4: A set strobe with `busIn[10]` high leaves the speed setting unchanged, whatever the shape group does.
- R5: A stored orientation bit of 1 means normal left-to-right text, so `rotateCcw` is 0. A stored bit of 0 means a quarter turn counterclockwise, so `rotateCcw` is 1.
- R6: `sizeDiv` reports the divide ratio for the stored size code: code 11 gives 2 (×1), 10 gives 3 (×1.5), 01 gives 4 (×2) and 00 gives 6 (×3).
- R7: A stored speed bit of 1 selects normal speed, so `slowSpeed` is 0. A stored bit of 0 selects slow speed, so `slowSpeed` is 1.
- R8: While `readStrobe` is high, `busOut` returns the stored size in bits 1:0, the orientation in bit 2 and the speed in bit 9. It returns 1 in bits 3 and 10 and 0 in every other bit, in the same cycle. While `readStrobe` is low, `busOut` is all zeros.
- R9: Without a set strobe, no change on `busIn` alters any stored setting.
- R10: Reset (`rstN` low) loads size code 11, normal orientation and normal speed. A readback then gives 16'h060F and `sizeDiv` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setStrobe | input | 1 | Write strobe, sampled on the rising edge |
| readStrobe | input | 1 | Drives the stored settings onto `busOut` |
| busIn | input | 16 | Data word carrying the fields and the change-enable bits |
| busOut | output | 16 | Readback word, zero when no read is in progress |
| sizeCode | output | 2 | Stored size code |
| rotateCcw | output | 1 | High when rotated text is selected |
| slowSpeed | output | 1 | High when slow writing speed is selected |
| sizeDiv | output | 3 | Stroke-clock divide ratio for the stored size |

## Verification
Writes are driven with every combination of the two change-enable bits. This separates a group that loads from a group that must hold, and it exposes any crosstalk between the shape enable and the speed enable. All four size codes and both levels of the orientation and speed bits are stored and then read back. Reads are placed in the same cycles as writes to show that the readback gives the settings from before the edge. Idle stretches with a changing data word and no strobe confirm that the settings persist.

// File: rtl/charStylePkg.sv
package charStylePkg;

  // Bit positions on the data word; the controller depends on this layout.
  localparam int SIZE_LO      = 0;
  localparam int SIZE_W       = 2;
  localparam int ORIENT_BIT   = 2;
  localparam int SHAPE_EN_BIT = 3;
  localparam int SPEED_BIT    = 9;
  localparam int SPEED_EN_BIT = 10;
  localparam int DIV_W        = 3;

  // Reset settings: x1 size, normal orientation, normal speed.
  localparam logic [SIZE_W-1:0] RESET_SIZE   = 2'b11;
  localparam logic              RESET_ORIENT = 1'b1;
  localparam logic              RESET_SPEED  = 1'b1;

  typedef struct packed {
    logic loadShape;
    logic loadSpeed;
    logic driveBus;
  } ctrlStrobes_t;

  function automatic logic [DIV_W-1:0] sizeToDiv(input logic [SIZE_W-1:0] code);
    logic [DIV_W-1:0] ratio;
    case (code)
      2'b11:   ratio = 3'd2;
      2'b10:   ratio = 3'd3;
      2'b01:   ratio = 3'd4;
      default: ratio = 3'd6;
    endcase
    return ratio;
  endfunction

endpackage

// File: rtl/charStyleCtrl.sv
module charStyleCtrl
  import charStylePkg::*;
(
  input  logic         setStrobe,
  input  logic         readStrobe,
  input  logic         shapeEnN,
  input  logic         speedEnN,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.loadShape = setStrobe & ~shapeEnN;
    strobes.loadSpeed = setStrobe & ~speedEnN;
    strobes.driveBus  = readStrobe;
  end

endmodule

// File: rtl/charStyleData.sv
module charStyleData
  import charStylePkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic [SIZE_W-1:0] sizeCode,
  output logic              rotateCcw,
  output logic              slowSpeed,
  output logic [DIV_W-1:0]  sizeDiv
);

  localparam logic [BUS_W-1:0] USED_MASK =
      (BUS_W'(2**SIZE_W - 1) << SIZE_LO) | (BUS_W'(1) << ORIENT_BIT) |
      (BUS_W'(1) << SHAPE_EN_BIT) | (BUS_W'(1) << SPEED_BIT) |
      (BUS_W'(1) << SPEED_EN_BIT);

  logic [SIZE_W-1:0] sizeQ;
  logic              orientQ;
  logic              speedQ;
  logic [BUS_W-1:0]  readWord;
  logic              unusedBusBits;

  assign unusedBusBits = ^(busIn & ~USED_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ   <= RESET_SIZE;
      orientQ <= RESET_ORIENT;
    end else if (strobes.loadShape) begin
      sizeQ   <= busIn[SIZE_LO +: SIZE_W];
      orientQ <= busIn[ORIENT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  speedQ <= RESET_SPEED;
    else if (strobes.loadSpeed) speedQ <= busIn[SPEED_BIT];
  end

  always_comb begin
    readWord                       = '0;
    readWord[SIZE_LO +: SIZE_W]    = sizeQ;
    readWord[ORIENT_BIT]           = orientQ;
    readWord[SHAPE_EN_BIT]         = 1'b1;
    readWord[SPEED_BIT]            = speedQ;
    readWord[SPEED_EN_BIT]         = 1'b1;
  end

  for (genvar b = 0; b < BUS_W; b++) begin : g_readGate
    assign busOut[b] = strobes.driveBus & readWord[b];
  end

  assign sizeCode  = sizeQ;
  assign rotateCcw = ~orientQ;
  assign slowSpeed = ~speedQ;
  assign sizeDiv   = sizeToDiv(sizeQ);

endmodule

// File: rtl/charStyleReg.sv
module charStyleReg
  import charStylePkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setStrobe,
  input  logic              readStrobe,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic [SIZE_W-1:0] sizeCode,
  output logic              rotateCcw,
  output logic              slowSpeed,
  output logic [DIV_W-1:0]  sizeDiv
);

  ctrlStrobes_t strobes;

  charStyleCtrl i_ctrl (
    .setStrobe (setStrobe),
    .readStrobe(readStrobe),
    .shapeEnN  (busIn[SHAPE_EN_BIT]),
    .speedEnN  (busIn[SPEED_EN_BIT]),
    .strobes   (strobes)
  );

  charStyleData #(.BUS_W(BUS_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busIn    (busIn),
    .busOut   (busOut),
    .sizeCode (sizeCode),
    .rotateCcw(rotateCcw),
    .slowSpeed(slowSpeed),
    .sizeDiv  (sizeDiv)
  );

endmodule

// File: rtl/charStyleCheck.sv
module charStyleCheck
  import charStylePkg::*;
#(
  parameter int BUS_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              setStrobe,
  input logic              readStrobe,
  input logic [BUS_W-1:0]  busIn,
  input logic [BUS_W-1:0]  busOut,
  input logic [SIZE_W-1:0] sizeCode,
  input logic              rotateCcw,
  input logic              slowSpeed,
  input logic [DIV_W-1:0]  sizeDiv
);

  p_shape_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe && !busIn[SHAPE_EN_BIT] |=>
      sizeCode == $past(busIn[SIZE_LO +: SIZE_W]) && rotateCcw == !$past(busIn[ORIENT_BIT]));

  p_speed_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe && !busIn[SPEED_EN_BIT] |=> slowSpeed == !$past(busIn[SPEED_BIT]));

  p_shape_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe && busIn[SHAPE_EN_BIT] |=> $stable(sizeCode) && $stable(rotateCcw));

  p_speed_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe && busIn[SPEED_EN_BIT] |=> $stable(slowSpeed));

  p_ratio_x3_r6: assert property (@(posedge clk) disable iff (!rstN)
    setStrobe && !busIn[SHAPE_EN_BIT] && busIn[SIZE_LO +: SIZE_W] == 2'b00 |=> sizeDiv == 3'd6);

  p_read_enables_r8: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |-> busOut[SHAPE_EN_BIT] && busOut[SPEED_EN_BIT]);

  p_read_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |-> busOut[SIZE_LO +: SIZE_W] == sizeCode && busOut[ORIENT_BIT] == !rotateCcw
                   && busOut[SPEED_BIT] == !slowSpeed);

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |-> busOut == '0);

  p_persist_r9: assert property (@(posedge clk) disable iff (!rstN)
    !setStrobe |=> $stable(sizeCode) && $stable(rotateCcw) && $stable(slowSpeed) && $stable(sizeDiv));

endmodule

bind charStyleReg charStyleCheck #(.BUS_W(BUS_W)) i_check (.*);

// File: tb/test_charStyleReg.sv
`timescale 1ns/1ps
module test_charStyleReg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setStrobe = 1'b0;
  logic        readStrobe = 1'b0;
  logic [15:0] busIn = '0;
  logic [15:0] busOut;
  logic [1:0]  sizeCode;
  logic        rotateCcw;
  logic        slowSpeed;
  logic [2:0]  sizeDiv;

  int checks = 0;
  int fails = 0;
  int mSize = 3;
  int mOrient = 1;
  int mSpeed = 1;

  always #10 clk = ~clk;

  charStyleReg i_charStyleReg (
    .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .readStrobe(readStrobe),
    .busIn(busIn), .busOut(busOut), .sizeCode(sizeCode), .rotateCcw(rotateCcw),
    .slowSpeed(slowSpeed), .sizeDiv(sizeDiv)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int ratioOf(input int code);
    case (code)
      3: return 2;
      2: return 3;
      1: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int modelWord();
    return mSize | (mOrient << 2) | (1 << 3) | (mSpeed << 9) | (1 << 10);
  endfunction

  task automatic checkState(input string tag);
    chk(tag, "R1 sizeCode", int'(sizeCode), mSize);
    chk(tag, "R5 rotateCcw", int'(rotateCcw), 1 - mOrient);
    chk(tag, "R7 slowSpeed", int'(slowSpeed), 1 - mSpeed);
    chk(tag, "R6 sizeDiv", int'(sizeDiv), ratioOf(mSize));
  endtask

  // Starts and ends at a falling edge.
  task automatic doCycle(input string tag, input logic s, input logic r, input logic [15:0] d);
    setStrobe = s; readStrobe = r; busIn = d;
    #2;
    chk(tag, "R8 busOut", int'(busOut), r ? modelWord() : 0);
    @(posedge clk);
    if (s) begin
      if (!d[3]) begin mSize = int'(d[1:0]); mOrient = int'(d[2]); end
      if (!d[10]) mSpeed = int'(d[9]);
    end
    @(negedge clk);
    checkState(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checkState("R10 reset");
    rstN = 1'b1;
    @(negedge clk);
    doCycle("R10 readback", 1'b0, 1'b1, 16'h0000);
    chk("R10", "reset word", modelWord(), 16'h060F);

    doCycle("R1 R2 both load", 1'b1, 1'b0, 16'h0000);
    doCycle("R8 read after load", 1'b0, 1'b1, 16'hFFFF);
    doCycle("R4 speed ignored", 1'b1, 1'b0, 16'h0601);
    doCycle("R3 shape ignored", 1'b1, 1'b1, 16'h0208);
    doCycle("R3 R4 both ignored", 1'b1, 1'b1, 16'hF5FE);
    for (int i = 0; i < 6; i++)
      doCycle("R9 idle", 1'b0, i[0], 16'hFFFF ^ 16'(i * 16'h1357));
    for (int c = 0; c < 4; c++)
      doCycle("R6 size sweep", 1'b1, 1'b1, 16'h0604 | 16'(c));
    doCycle("R5 rotate", 1'b1, 1'b1, 16'h0400);
    doCycle("R7 slow", 1'b1, 1'b1, 16'h0008);
    doCycle("R7 normal", 1'b1, 1'b0, 16'h0208);
    for (int p = 0; p < 64; p++) begin
      logic [15:0] w;
      w = 16'(p & 7) | (16'((p >> 3) & 1) << 3) | (16'((p >> 4) & 1) << 9)
        | (16'((p >> 5) & 1) << 10) | (16'(p * 16'h0931) & 16'hF9F0);
      doCycle("R1 R2 R3 R4 sweep", 1'b1, p[1], w);
      doCycle("R8 R9 sweep read", 1'b0, 1'b1, ~w);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule